// File: doc/BRIEF.md
# Segment Presence Filter

This block sits beside a large die-stacked DRAM cache and answers a single question for every last-level miss: is the 64-byte block resident in that cache? It tracks memory in 4 KB segments. Each tracked segment owns one entry, which holds the segment tag and a 64-bit vector with one presence bit per block. The entries are arranged as a set-associative array. A lookup returns one of three answers. *present* means the request should probe the DRAM cache. *absent* means it should go straight to main memory. *untracked* means no entry covers the segment, and the filter has just allocated one with every bit clear.

The DRAM cache controller reports its own fills and removals on two update ports. A fill sets the block's bit and a removal clears it. Updates for segments the filter does not track are discarded. When an allocation has to displace a valid entry, the filter emits one eviction request for each block the displaced entry still marks present. The DRAM cache then drops those blocks, writing back the dirty ones. Because of this, an *absent* answer is never wrong.

Top module: `missmap_filter`

## Requirements
- R1: During reset and just after it, `res_valid` and `ev_valid` are low and `lk_ready` is high while no update is presented.
- R2: Address fields are byte offset in bits [5:0], block-in-segment in [11:6], set in [12 +: log2(SETS)] and tag above that. A lookup that hits a tracked segment returns code 1 (present) if the block's bit is set and code 2 (absent) if it is clear.
- R3: A lookup to an untracked segment returns code 3 (untracked) and allocates an entry whose presence bits are all clear. A second lookup to that segment then returns code 2.
- R4: A fill sets the block's bit and a drop clears it. Either one is visible to a lookup accepted in the following cycle. When a fill and a drop name the same block in the same cycle, the drop wins.
- R5: A fill or drop whose segment is not tracked changes nothing and allocates nothing.
- R6: An allocation takes an invalid way in the set if one exists. Otherwise it takes the least recently used way. Both hits and allocations count as uses.
- R7: Displacing an entry issues one eviction request for each set presence bit, in ascending block order. Each request carries the address tag,set,block,6'b0. `ev_addr` holds steady while `ev_valid` is high and `ev_ready` is low.
- R8: While eviction requests are pending, a lookup to the displaced entry's set, or a lookup that misses, is refused (`lk_ready` low). A lookup that hits in another set is accepted.
- R9: `lk_ready` is low in any cycle in which a fill or a drop is presented.
- R10: `res_valid` is high exactly in the cycle after a lookup is accepted, and `res_code` is then nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_ready | output | 1 | Lookup accepted this cycle when high with lk_valid |
| res_valid | output | 1 | Lookup result valid |
| res_code | output | 2 | 1 present, 2 absent, 3 untracked (allocated) |
| fill_valid | input | 1 | A block was filled into the DRAM cache |
| fill_addr | input | ADDR_W | Address of the filled block |
| drop_valid | input | 1 | A block was removed from the DRAM cache |
| drop_addr | input | ADDR_W | Address of the removed block |
| ev_valid | output | 1 | Eviction request pending |
| ev_addr | output | ADDR_W | Block address to evict from the DRAM cache |
| ev_ready | input | 1 | Eviction request accepted |

## Verification
A corrupted presence bit shows up as a wrong present/absent code on the first later lookup to that block. That is one cycle after the lookup is accepted. Broken recency state or a wrong victim choice stays hidden until the set fills up. It then appears as an unexpected untracked result for a surviving segment, or as an eviction stream carrying the wrong segment's addresses in the cycle after the allocation. A lost or reordered pending eviction shows up as `ev_addr` differing from the expected ascending sequence, or as `lk_ready` falling or rising in the wrong cycle. The bench runs a behavioural model with per-set recency lists and compares these outputs on every clock.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;
  localparam int BLK_OFS_W = 6;   // 64-byte blocks
  localparam int SEG_IDX_W = 6;   // 64 blocks per 4 KB segment
  localparam int SEG_BLKS  = 1 << SEG_IDX_W;
  localparam int SEG_SHIFT = BLK_OFS_W + SEG_IDX_W;

  typedef enum logic [1:0] {
    RES_NONE      = 2'd0,
    RES_PRESENT   = 2'd1,
    RES_ABSENT    = 2'd2,
    RES_UNTRACKED = 2'd3
  } res_e;
endpackage

// File: rtl/mm_way_match.sv
`timescale 1ns/1ps
module mm_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 18,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [WAY_W-1:0]      way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/mm_victim_pick.sv
`timescale 1ns/1ps
module mm_victim_pick #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*WAY_W-1:0] ages,
  output logic [WAY_W-1:0]      victim
);
  logic             found;
  logic [WAY_W-1:0] oldest;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    oldest = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w*WAY_W +: WAY_W] >= oldest) begin
          oldest = ages[w*WAY_W +: WAY_W];
          victim = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/mm_evict_drain.sv
`timescale 1ns/1ps
module mm_evict_drain
  import mm_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int SEG_W = ADDR_W - SEG_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SEG_W-1:0]    load_seg,
  input  logic [SEG_BLKS-1:0] load_bits,
  input  logic                ev_ready,
  output logic                ev_valid,
  output logic [ADDR_W-1:0]   ev_addr
);
  logic [SEG_BLKS-1:0]  pend_q;
  logic [SEG_W-1:0]     seg_q;
  logic [SEG_IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = SEG_BLKS - 1; i >= 0; i--) begin
      if (pend_q[i]) low_idx = SEG_IDX_W'(i);
    end
  end

  assign ev_valid = |pend_q;
  assign ev_addr  = {seg_q, low_idx, {BLK_OFS_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      seg_q  <= '0;
    end else if (load) begin
      pend_q <= load_bits;
      seg_q  <= load_seg;
    end else if (ev_valid && ev_ready) begin
      pend_q[low_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/missmap_filter.sv
`timescale 1ns/1ps
module missmap_filter
  import mm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              res_valid,
  output logic [1:0]        res_code,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              drop_valid,
  input  logic [ADDR_W-1:0] drop_addr,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_ready
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SEG_SHIFT - SET_W;
  localparam int NPORT = 3;   // 0 lookup, 1 fill, 2 drop

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[SEG_SHIFT +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SEG_IDX_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[BLK_OFS_W +: SEG_IDX_W];
  endfunction

  logic                vld_q  [SETS][WAYS];
  logic [TAG_W-1:0]    tag_q  [SETS][WAYS];
  logic [SEG_BLKS-1:0] bits_q [SETS][WAYS];
  logic [WAY_W-1:0]    age_q  [SETS][WAYS];

  logic [ADDR_W-1:0]     q_addr [NPORT];
  logic [SET_W-1:0]      q_set  [NPORT];
  logic [TAG_W-1:0]      q_tag  [NPORT];
  logic [SEG_IDX_W-1:0]  q_blk  [NPORT];
  logic [WAYS-1:0]       q_vld  [NPORT];
  logic [WAYS*TAG_W-1:0] q_tags [NPORT];
  logic                  q_hit  [NPORT];
  logic [WAY_W-1:0]      q_way  [NPORT];

  assign q_addr[0] = lk_addr;
  assign q_addr[1] = fill_addr;
  assign q_addr[2] = drop_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign q_set[p] = set_of(q_addr[p]);
    assign q_tag[p] = tag_of(q_addr[p]);
    assign q_blk[p] = blk_of(q_addr[p]);
    for (genvar w = 0; w < WAYS; w++) begin : g_row
      assign q_vld[p][w]                  = vld_q[q_set[p]][w];
      assign q_tags[p][w*TAG_W +: TAG_W]  = tag_q[q_set[p]][w];
    end
    mm_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .vld (q_vld[p]),
      .tags(q_tags[p]),
      .key (q_tag[p]),
      .hit (q_hit[p]),
      .way (q_way[p])
    );
  end

  logic [WAYS*WAY_W-1:0] lk_ages;
  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign lk_ages[w*WAY_W +: WAY_W] = age_q[q_set[0]][w];
  end

  logic [WAY_W-1:0] victim;
  mm_victim_pick #(.WAYS(WAYS)) u_victim (
    .vld   (q_vld[0]),
    .ages  (lk_ages),
    .victim(victim)
  );

  // named internal events
  logic             upd_any, lk_fire, lk_hit, alloc, ev_load, lk_bit;
  logic [SET_W-1:0] drain_set_q;
  logic [WAY_W-1:0] touch_way, touch_age;
  logic             fill_hit, drop_hit;

  assign upd_any   = fill_valid || drop_valid;
  assign lk_hit    = q_hit[0];
  assign lk_ready  = !upd_any && !(ev_valid && ((q_set[0] == drain_set_q) || !lk_hit));
  assign lk_fire   = lk_valid && lk_ready;
  assign alloc     = lk_fire && !lk_hit;
  assign ev_load   = alloc && vld_q[q_set[0]][victim];
  assign touch_way = lk_hit ? q_way[0] : victim;
  assign touch_age = age_q[q_set[0]][touch_way];
  assign lk_bit    = bits_q[q_set[0]][q_way[0]][q_blk[0]];
  assign fill_hit  = fill_valid && q_hit[1];
  assign drop_hit  = drop_valid && q_hit[2];

  mm_evict_drain #(.ADDR_W(ADDR_W)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .load_seg ({tag_q[q_set[0]][victim], q_set[0]}),
    .load_bits(bits_q[q_set[0]][victim]),
    .ev_ready (ev_ready),
    .ev_valid (ev_valid),
    .ev_addr  (ev_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_code    <= RES_NONE;
      drain_set_q <= '0;
    end else begin
      res_valid <= lk_fire;
      if (lk_fire) res_code <= !lk_hit ? RES_UNTRACKED : (lk_bit ? RES_PRESENT : RES_ABSENT);
      if (ev_load) drain_set_q <= q_set[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          tag_q[s][w]  <= '0;
          bits_q[s][w] <= '0;
          age_q[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (alloc && SET_W'(s) == q_set[0] && WAY_W'(w) == victim) begin
            vld_q[s][w]  <= 1'b1;
            tag_q[s][w]  <= q_tag[0];
            bits_q[s][w] <= '0;
          end
          if (fill_hit && SET_W'(s) == q_set[1] && WAY_W'(w) == q_way[1])
            bits_q[s][w][q_blk[1]] <= 1'b1;
          if (drop_hit && SET_W'(s) == q_set[2] && WAY_W'(w) == q_way[2])
            bits_q[s][w][q_blk[2]] <= 1'b0;
          if (lk_fire && SET_W'(s) == q_set[0]) begin
            if (WAY_W'(w) == touch_way)      age_q[s][w] <= '0;
            else if (age_q[s][w] < touch_age) age_q[s][w] <= age_q[s][w] + 1'b1;
          end
        end
      end
    end
  end

  logic unused_lowbits;
  assign unused_lowbits = ^{lk_addr[BLK_OFS_W-1:0], fill_addr[BLK_OFS_W-1:0],
                            drop_addr[BLK_OFS_W-1:0]};
endmodule

// File: rtl/missmap_filter_chk.sv
`timescale 1ns/1ps
module missmap_filter_chk #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_ready,
  input logic              res_valid,
  input logic [1:0]        res_code,
  input logic              fill_valid,
  input logic              drop_valid,
  input logic              ev_valid,
  input logic [ADDR_W-1:0] ev_addr,
  input logic              ev_ready,
  input logic              lk_fire,
  input logic              alloc,
  input logic              ev_load
);
  p_res_follows_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> res_valid);
  p_res_only_after_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !res_valid);
  p_code_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code != 2'd0);
  p_alloc_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> res_code == 2'd3);
  p_ev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr)));
  p_ev_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_addr[5:0] == 6'd0);
  p_stall_drain_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && lk_addr[12 +: SET_W] == ev_addr[12 +: SET_W]) |-> !lk_ready);
  p_load_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> !ev_valid);
  p_stall_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || drop_valid) |-> !lk_ready);

  logic unused_chk;
  assign unused_chk = ^{lk_addr, ev_addr};
endmodule

bind missmap_filter missmap_filter_chk #(.ADDR_W(ADDR_W), .SET_W($clog2(SETS))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_addr   (lk_addr),
  .lk_ready  (lk_ready),
  .res_valid (res_valid),
  .res_code  (res_code),
  .fill_valid(fill_valid),
  .drop_valid(drop_valid),
  .ev_valid  (ev_valid),
  .ev_addr   (ev_addr),
  .ev_ready  (ev_ready),
  .lk_fire   (lk_fire),
  .alloc     (alloc),
  .ev_load   (ev_load)
);

// File: tb/missmap_filter_tb.sv
`timescale 1ns/1ps
module missmap_filter_tb;
  localparam int ADDR_W = 32;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              lk_valid = 1'b0, fill_valid = 1'b0, drop_valid = 1'b0, ev_ready = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0, fill_addr = '0, drop_addr = '0;
  logic              lk_ready, res_valid, ev_valid;
  logic [1:0]        res_code;
  logic [ADDR_W-1:0] ev_addr;

  missmap_filter #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dut (.*);

  always #2 clk = ~clk;   // 250 MHz

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural model: per set, lists in most-recent-first order
  int unsigned mtag  [SETS][$];
  logic [63:0] mbits [SETS][$];
  logic [31:0] evq[$];
  int          bset = 0;
  bit          exp_rv;
  logic [1:0]  exp_rc;
  logic        seen_ready, seen_evv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int b);
    return (32'(t) << 14) | (32'(s) << 12) | (32'(b) << 6);
  endfunction

  function automatic int find(input int s, input int unsigned t);
    for (int i = 0; i < mtag[s].size(); i++) if (mtag[s][i] == t) return i;
    return -1;
  endfunction

  task automatic upd(input logic [31:0] a, input bit val);
    int s, i;
    s = int'(a[13:12]);
    i = find(s, int'(a[31:14]));
    if (i >= 0) mbits[s][i][a[11:6]] = val;
  endtask

  task automatic tick();
    int ls, lb, idx;
    int unsigned lt, vt;
    bit er;
    logic [63:0] b;
    #2;
    ls  = int'(lk_addr[13:12]);
    lt  = int'(lk_addr[31:14]);
    lb  = int'(lk_addr[11:6]);
    idx = find(ls, lt);
    er  = !(fill_valid || drop_valid) && !(evq.size() > 0 && (ls == bset || idx < 0));
    seen_ready = lk_ready;
    seen_evv   = ev_valid;
    chk(lk_ready === er, "R8 R9 lk_ready", 32'(lk_ready), 32'(er));
    chk(ev_valid === (evq.size() > 0), "R7 ev_valid", 32'(ev_valid), 32'(evq.size() > 0));
    if (evq.size() > 0) chk(ev_addr === evq[0], "R7 ev_addr", ev_addr, evq[0]);
    @(posedge clk);
    if (ev_ready && evq.size() > 0) void'(evq.pop_front());
    if (fill_valid) upd(fill_addr, 1'b1);
    if (drop_valid) upd(drop_addr, 1'b0);
    exp_rv = lk_valid && er;
    if (exp_rv) begin
      if (idx >= 0) begin
        b = mbits[ls][idx];
        exp_rc = b[lb] ? 2'd1 : 2'd2;
        mtag[ls].delete(idx);
        mbits[ls].delete(idx);
        mtag[ls].push_front(lt);
        mbits[ls].push_front(b);
      end else begin
        exp_rc = 2'd3;
        if (mtag[ls].size() == WAYS) begin
          vt = mtag[ls].pop_back();
          b  = mbits[ls].pop_back();
          for (int k = 0; k < 64; k++) if (b[k]) evq.push_back(mk(int'(vt), ls, k));
          bset = ls;
        end
        mtag[ls].push_front(lt);
        mbits[ls].push_front(64'd0);
      end
    end
    #1;
    chk(res_valid === exp_rv, "R10 res_valid", 32'(res_valid), 32'(exp_rv));
    if (exp_rv) chk(res_code === exp_rc, "R2 R3 res_code", 32'(res_code), 32'(exp_rc));
  endtask

  task automatic drive(input bit lv, input logic [31:0] la, input bit fv, input logic [31:0] fa,
                       input bit dv, input logic [31:0] da, input bit er);
    lk_valid = lv; lk_addr = la; fill_valid = fv; fill_addr = fa;
    drop_valid = dv; drop_addr = da; ev_ready = er;
    tick();
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] code, input string req);
    drive(1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0);
    chk(res_valid === 1'b1 && res_code === code, req, 32'(res_code), 32'(code));
  endtask

  task automatic fill(input logic [31:0] a);
    drive(1'b0, '0, 1'b1, a, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(res_valid === 1'b0, "R1 res_valid", 32'(res_valid), 0);
    chk(ev_valid === 1'b0, "R1 ev_valid", 32'(ev_valid), 0);
    chk(lk_ready === 1'b1, "R1 lk_ready", 32'(lk_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    look(mk(1, 0, 5), 2'd3, "R3 first lookup untracked");
    look(mk(1, 0, 5), 2'd2, "R3 new entry bits clear");
    fill(mk(1, 0, 5));
    look(mk(1, 0, 5), 2'd1, "R4 fill sets bit");
    drive(1'b0, '0, 1'b1, mk(1, 0, 7), 1'b1, mk(1, 0, 7), 1'b0);
    chk(seen_ready === 1'b0, "R9 ready low on update", 32'(seen_ready), 0);
    look(mk(1, 0, 7), 2'd2, "R4 drop wins over fill");
    look(mk(1, 0, 5), 2'd1, "R4 other bit kept");

    fill(mk(2, 0, 0));                          // R5: untracked segment
    look(mk(2, 0, 0), 2'd3, "R5 update did not allocate");
    look(mk(2, 0, 0), 2'd2, "R5 update left no bit");

    look(mk(1, 0, 5), 2'd1, "R6 refresh A");    // segment 2 becomes least recent
    look(mk(3, 0, 0), 2'd3, "R6 third segment allocates");
    chk(ev_valid === 1'b0, "R7 empty victim sends nothing", 32'(ev_valid), 0);
    look(mk(1, 0, 5), 2'd1, "R6 recent entry survives");
    look(mk(2, 0, 0), 2'd3, "R6 LRU entry was replaced");

    // R7 / R8: victim with blocks 0, 3, 63 present
    look(mk(4, 1, 0), 2'd3, "R3 set1 D");
    fill(mk(4, 1, 0)); fill(mk(4, 1, 3)); fill(mk(4, 1, 63));
    look(mk(5, 1, 0), 2'd3, "R3 set1 E");
    look(mk(6, 1, 2), 2'd3, "R6 set1 F displaces D");
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
    chk(seen_evv === 1'b1 && ev_addr === mk(4, 1, 0), "R7 first eviction", ev_addr, mk(4, 1, 0));
    drive(1'b1, mk(5, 1, 0), 1'b0, '0, 1'b0, '0, 1'b0);
    chk(seen_ready === 1'b0 && res_valid === 1'b0, "R8 victim set stalls", 32'(seen_ready), 0);
    drive(1'b1, mk(7, 2, 0), 1'b0, '0, 1'b0, '0, 1'b0);
    chk(seen_ready === 1'b0, "R8 miss stalls during drain", 32'(seen_ready), 0);
    look(mk(1, 0, 5), 2'd1, "R8 hit in other set proceeds");
    chk(ev_addr === mk(4, 1, 0), "R7 address held", ev_addr, mk(4, 1, 0));
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
    chk(ev_addr === mk(4, 1, 3), "R7 ascending order", ev_addr, mk(4, 1, 3));
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
    chk(ev_addr === mk(4, 1, 63), "R7 last block", ev_addr, mk(4, 1, 63));
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
    chk(ev_valid === 1'b0, "R7 drain complete", 32'(ev_valid), 0);
    look(mk(4, 1, 0), 2'd3, "R7 displaced segment untracked");

    // mixed traffic checked against the model every clock
    for (int n = 0; n < 3000; n++) begin
      int t, s, b, r;
      r = int'($urandom % 100);
      t = int'($urandom % 4); s = int'($urandom % SETS); b = int'($urandom % 4);
      lk_valid = (r < 60); lk_addr = mk(t, s, b);
      t = int'($urandom % 4); s = int'($urandom % SETS); b = int'($urandom % 4);
      fill_valid = ($urandom % 4 == 0); fill_addr = mk(t, s, b);
      t = int'($urandom % 4); s = int'($urandom % SETS); b = int'($urandom % 4);
      drop_valid = ($urandom % 7 == 0); drop_addr = mk(t, s, b);
      ev_ready = ($urandom % 2 == 0);
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule